// File: doc/BRIEF.md
# NAND Page Hamming Parity Engine

This engine sits beside the byte path of a NAND flash controller. It accumulates single-error-correcting Hamming parity over the bytes strobed through it, and produces three parity bytes for each 256-byte segment. With the default configuration a 512-byte page gives two segments and six parity bytes.

Host software drives the engine with a 2-bit mode: clear, accumulate, read-out or idle. The usual sequence is clear, idle, then accumulate while the page moves. After the transfer the sequence is idle, read-out, a run of read strobes to collect the parity, then idle again. In read-out mode each 3-byte group comes out with its middle byte first. Comparing the stored parity with freshly computed parity lets the host find and flip any single bad bit in a segment.

Top module: `nand_ecc_engine`

## Requirements
- R1: After reset, `ecc_o` is 0xFF, and reading all parity bytes before any data is accumulated returns 0xFF for every byte.
- R2: The mode encodings are 2'b11 clear, 2'b01 accumulate, 2'b10 read-out and 2'b00 idle. A byte strobed while the mode is idle or read-out changes neither the parity nor the byte position.
- R3: The column parity bits are each the XOR, over every accepted byte in the segment, of these data bits: CP0 = bits 0,2,4,6; CP1 = bits 1,3,5,7; CP2 = bits 0,1,4,5; CP3 = bits 2,3,6,7; CP4 = bits 0..3; CP5 = bits 4..7.
- R4: For each byte-index bit k (0..7) within the segment, LP(2k+1) is the XOR of the parities of the bytes whose index has bit k set, and LP(2k) is the XOR of the parities of those whose index has bit k clear.
- R5: Each segment stores three bytes, all bitwise complemented: P0 bit j = ~LP(j), P1 bit j = ~LP(8+j), P2 bits 7:2 = ~CP5..~CP0 with bits 1:0 = 1. An all-zero segment gives FF FF FF.
- R6: Segment boundaries fall every 256 accepted bytes. Once NUM_SEG segments are full, further bytes are ignored.
- R7: In read-out mode, each read strobe places the next parity byte on `ecc_o` in the following cycle. The order is segment 0 first, and within each group P1, then P0, then P2.
- R8: Whenever the mode is anything other than read-out, the read position returns to the first byte.
- R9: Read strobes beyond the last stored byte return 0xFF.
- R10: The clear mode zeroes all parity accumulators, the byte position and the segment index.
- R11: When a single data bit in a segment is flipped, the XOR of old and new parity has exactly one bit set in every (even, odd) pair. The odd bits spell the byte index and the bit position, and the other segments are unaffected.
- R12: A read strobe outside read-out mode leaves `ecc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Engine mode (11 clear, 01 accumulate, 10 read-out, 00 idle) |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte on the flash path |
| rd_i | input | 1 | Parity read strobe |
| ecc_o | output | 8 | Parity byte returned by the last read |

## Verification
A corrupted accumulator bit reaches the ports as a single wrong bit in one parity byte, and it shows only at read-out after a page. The bench therefore compares all six bytes against its own model over several data patterns. A byte counter that is off by one, or that counts in the wrong mode, moves every later byte's line parity and shifts work into the wrong segment. Page lengths at, below and beyond 512 bytes, and strobes made in idle and read-out modes, make such faults visible. A read pointer that is wrong shows at once on the next read as a permuted or repeated byte, so the order, restart and past-end reads are checked one strobe at a time.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_ACC  = 2'b01,
    MODE_READ = 2'b10,
    MODE_CLR  = 2'b11
  } ecc_mode_e;

  localparam int SEG_AW    = 8;
  localparam int SEG_BYTES = 1 << SEG_AW;
  localparam int GRP_BYTES = 3;
  localparam int GRP_W     = 8 * GRP_BYTES;

  // read-out slot r of a group -> stored byte number (P1, P0, P2)
  function automatic int grp_slot(input int r);
    case (r)
      0:       return 1;
      1:       return 0;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/nand_ecc_col_par.sv
module nand_ecc_col_par (
  input  logic [7:0] d_i,
  output logic [5:0] col_o,
  output logic       par_o
);
  assign col_o[0] = d_i[0] ^ d_i[2] ^ d_i[4] ^ d_i[6];
  assign col_o[1] = d_i[1] ^ d_i[3] ^ d_i[5] ^ d_i[7];
  assign col_o[2] = d_i[0] ^ d_i[1] ^ d_i[4] ^ d_i[5];
  assign col_o[3] = d_i[2] ^ d_i[3] ^ d_i[6] ^ d_i[7];
  assign col_o[4] = ^d_i[3:0];
  assign col_o[5] = ^d_i[7:4];
  assign par_o    = ^d_i;
endmodule

// File: rtl/nand_ecc_seg_acc.sv
module nand_ecc_seg_acc
  import nand_ecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [SEG_AW-1:0] idx_i,
  input  logic              par_i,
  input  logic [5:0]        col_i,
  output logic [GRP_W-1:0]  ecc_o
);
  localparam int LPW = 2 * SEG_AW;

  logic [LPW-1:0] lp_q, lp_d;
  logic [5:0]     cp_q;

  always_comb begin
    lp_d = lp_q;
    if (par_i) begin
      for (int k = 0; k < SEG_AW; k++) begin
        lp_d[2*k]   = lp_q[2*k]   ^ ~idx_i[k];
        lp_d[2*k+1] = lp_q[2*k+1] ^  idx_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr_i) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (en_i) begin
      lp_q <= lp_d;
      cp_q <= cp_q ^ col_i;
    end
  end

  // byte2 = P2, byte1 = P1, byte0 = P0, all complemented
  assign ecc_o = {~{cp_q, 2'b00}, ~lp_q[15:8], ~lp_q[7:0]};

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ecc_o == {GRP_W{1'b1}});

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(ecc_o));

endmodule

// File: rtl/nand_ecc_readout.sv
module nand_ecc_readout
  import nand_ecc_pkg::*;
#(
  parameter int NUM_SEG = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_mode_i,
  input  logic                     rd_i,
  input  logic [NUM_SEG*GRP_W-1:0] bytes_i,
  output logic [7:0]               ecc_o
);
  localparam int NBYTES = NUM_SEG * GRP_BYTES;
  localparam int PW     = $clog2(NBYTES + 1);

  logic [PW-1:0] ptr_q;
  logic [7:0]    sel;
  logic          in_range;

  assign in_range = ptr_q < PW'(NBYTES);

  always_comb begin
    sel = 8'hFF;
    for (int e = 0; e < NBYTES; e++) begin
      if (ptr_q == PW'(e))
        sel = bytes_i[(e / GRP_BYTES) * GRP_W + grp_slot(e % GRP_BYTES) * 8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ecc_o <= 8'hFF;
    end else if (!rd_mode_i) begin
      ptr_q <= '0;
    end else if (rd_i) begin
      if (in_range) begin
        ecc_o <= sel;
        ptr_q <= ptr_q + 1'b1;
      end else begin
        ecc_o <= 8'hFF;
      end
    end
  end

  assert_ptr_home_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_mode_i |=> ptr_q == '0);

  assert_past_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mode_i && rd_i && !in_range) |=> ecc_o == 8'hFF);

  assert_no_stray_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_mode_i && rd_i) |=> $stable(ecc_o));

  assert_ptr_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PW'(NBYTES));

endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int NUM_SEG = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       rd_i,
  output logic [7:0] ecc_o
);
  localparam int SW = $clog2(NUM_SEG + 1);

  ecc_mode_e mode;
  assign mode = ecc_mode_e'(mode_i);

  logic [SEG_AW-1:0]        cnt_q;
  logic [SW-1:0]            seg_q;
  logic                     clr, acc_en;
  logic [5:0]               col;
  logic                     par;
  logic [NUM_SEG*GRP_W-1:0] all_bytes;

  assign clr    = (mode == MODE_CLR);
  assign acc_en = (mode == MODE_ACC) && byte_vld_i && (seg_q < SW'(NUM_SEG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      seg_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      seg_q <= '0;
    end else if (acc_en) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) seg_q <= seg_q + 1'b1;
    end
  end

  nand_ecc_col_par u_col (
    .d_i   (byte_i),
    .col_o (col),
    .par_o (par)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    nand_ecc_seg_acc u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (acc_en && (seg_q == SW'(g))),
      .idx_i  (cnt_q),
      .par_i  (par),
      .col_i  (col),
      .ecc_o  (all_bytes[g*GRP_W +: GRP_W])
    );
  end

  nand_ecc_readout #(.NUM_SEG(NUM_SEG)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_mode_i (mode == MODE_READ),
    .rd_i      (rd_i),
    .bytes_i   (all_bytes),
    .ecc_o     (ecc_o)
  );

  assert_seg_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_q <= SW'(NUM_SEG));

  assert_seg_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en && (&cnt_q)) |=> (seg_q == $past(seg_q) + 1'b1) && (cnt_q == '0));

  assert_no_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_IDLE || mode == MODE_READ) |=> $stable(cnt_q) && $stable(seg_q));

  assert_full_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q == SW'(NUM_SEG) && !clr) |=> $stable(cnt_q) && $stable(seg_q));

endmodule

// File: tb/tb_nand_ecc_engine.sv
`timescale 1ns/1ps
module tb_nand_ecc_engine;
  localparam int NSEG = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       rd_i = 1'b0;
  logic [7:0] ecc_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] pg [0:767];
  logic [7:0] got [0:7];

  always #2.5 clk = ~clk;

  nand_ecc_engine #(.NUM_SEG(NSEG)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .rd_i(rd_i), .ecc_o(ecc_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // reference parity of segment s over the first n page bytes: {P2,P1,P0}
  function automatic logic [23:0] ref_seg(input int s, input int n);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = s*256; i < s*256 + 256 && i < n; i++) begin
      logic [7:0] d = pg[i];
      cp[0] ^= d[0]^d[2]^d[4]^d[6];
      cp[1] ^= d[1]^d[3]^d[5]^d[7];
      cp[2] ^= d[0]^d[1]^d[4]^d[5];
      cp[3] ^= d[2]^d[3]^d[6]^d[7];
      cp[4] ^= d[0]^d[1]^d[2]^d[3];
      cp[5] ^= d[4]^d[5]^d[6]^d[7];
      if (^d) begin
        for (int k = 0; k < 8; k++) begin
          if ((i % 256) & (1 << k)) lp[2*k+1] ^= 1'b1;
          else                      lp[2*k]   ^= 1'b1;
        end
      end
    end
    return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_i = m; byte_vld_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic send(input int from, input int n);
    for (int i = from; i < from + n; i++) begin
      @(negedge clk); byte_vld_i = 1'b1; byte_i = pg[i % 768];
    end
    @(negedge clk); byte_vld_i = 1'b0;
  endtask

  task automatic send_junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_vld_i = 1'b1; byte_i = 8'(i * 37 + 5);
    end
    @(negedge clk); byte_vld_i = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0; v = ecc_o;
  endtask

  task automatic read_all(input int n);
    set_mode(2'b00);
    set_mode(2'b10);
    for (int i = 0; i < n; i++) rd(got[i]);
  endtask

  task automatic run_page(input int n);
    set_mode(2'b11);
    set_mode(2'b00);
    set_mode(2'b01);
    send(0, n);
    read_all(6);
  endtask

  task automatic cmp_ref(input string req, input int n);
    for (int s = 0; s < NSEG; s++) begin
      logic [23:0] e = ref_seg(s, n);
      chk(req, got[3*s+0], e[15:8]);
      chk(req, got[3*s+1], e[7:0]);
      chk(req, got[3*s+2], e[23:16]);
    end
  endtask

  task automatic fill(input int kind);
    logic [31:0] x = 32'h1234_5678;
    for (int i = 0; i < 768; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      case (kind)
        0: pg[i] = 8'h00;
        1: pg[i] = 8'(i);
        2: pg[i] = x[31:24];
        default: pg[i] = 8'(~i * 3);
      endcase
    end
  endtask

  task automatic t_reset;
    chk("R1 reset out", ecc_o, 8'hFF);
    read_all(6);
    for (int i = 0; i < 6; i++) chk("R1 empty parity", got[i], 8'hFF);
  endtask

  task automatic t_single_byte;
    fill(0);
    pg[0] = 8'h01;
    run_page(1);
    // R5: lp=5555, cp=010101 -> P1=AA P0=AA P2=AB
    chk("R5 P1", got[0], 8'hAA);
    chk("R5 P0", got[1], 8'hAA);
    chk("R5 P2", got[2], 8'hAB);
    for (int i = 3; i < 6; i++) chk("R6 untouched seg", got[i], 8'hFF);
  endtask

  task automatic t_patterns;
    fill(0); run_page(512); cmp_ref("R5 zero page", 512);
    fill(1); run_page(512); cmp_ref("R3 R4 R7 ramp page", 512);
    fill(2); run_page(512); cmp_ref("R3 R4 R7 random page", 512);
    fill(3); run_page(300); cmp_ref("R6 partial page", 300);
  endtask

  task automatic t_overflow;
    fill(2); run_page(700); cmp_ref("R6 overflow ignored", 512);
  endtask

  task automatic t_mode_ignore;
    fill(2);
    set_mode(2'b11); set_mode(2'b00);
    send_junk(20);
    set_mode(2'b01); send(0, 100);
    set_mode(2'b00); send_junk(40);
    set_mode(2'b10); send_junk(40);
    set_mode(2'b01); send(100, 412);
    read_all(6);
    cmp_ref("R2 idle/read bytes ignored", 512);
  endtask

  task automatic t_clear;
    fill(1);
    set_mode(2'b01); send_junk(333);
    set_mode(2'b11); set_mode(2'b00);
    read_all(6);
    for (int i = 0; i < 6; i++) chk("R10 cleared", got[i], 8'hFF);
    set_mode(2'b01); send(0, 512);
    read_all(6);
    cmp_ref("R10 fresh after clear", 512);
  endtask

  task automatic t_readout;
    logic [7:0] v;
    logic [23:0] e0;
    fill(2); run_page(512);
    e0 = ref_seg(0, 512);
    set_mode(2'b00); set_mode(2'b10);
    rd(v); rd(v);
    set_mode(2'b00); set_mode(2'b10);
    rd(v); chk("R8 restart first", v, e0[15:8]);
    read_all(8);
    chk("R9 past end", got[6], 8'hFF);
    chk("R9 past end 2", got[7], 8'hFF);
    // R12: strobes outside read-out leave the output alone
    set_mode(2'b00);
    v = ecc_o;
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    chk("R12 stray read", ecc_o, v);
    set_mode(2'b01);
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    chk("R12 read in acc", ecc_o, v);
  endtask

  task automatic t_single_bit;
    logic [7:0] a [0:5];
    logic [15:0] lx;
    logic [7:0]  cx;
    logic [7:0]  idx;
    logic [2:0]  bp;
    int ok;
    fill(2); run_page(512);
    for (int i = 0; i < 6; i++) a[i] = got[i];
    pg[77] = pg[77] ^ 8'h20;
    run_page(512);
    lx = {a[0] ^ got[0], a[1] ^ got[1]};
    cx = a[2] ^ got[2];
    ok = 1;
    for (int k = 0; k < 8; k++) begin
      if ((lx[2*k] ^ lx[2*k+1]) != 1'b1) ok = 0;
      idx[k] = lx[2*k+1];
    end
    for (int k = 0; k < 3; k++) begin
      if ((cx[2+2*k] ^ cx[3+2*k]) != 1'b1) ok = 0;
      bp[k] = cx[3+2*k];
    end
    chk("R11 pairs complementary", 8'(ok), 8'd1);
    chk("R11 byte index", idx, 8'd77);
    chk("R11 bit index", {5'd0, bp}, 8'd5);
    chk("R11 spare bits", cx & 8'h03, 8'h00);
    for (int i = 3; i < 6; i++) chk("R11 other seg", got[i], a[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_byte();
    t_patterns();
    t_overflow();
    t_mode_ignore();
    t_clear();
    t_readout();
    t_single_bit();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule